// File: doc/BRIEF.md
# DDR Read Sample-Cycle Tracker

This block chooses which of four DDR 1X cycles (index 0 to 3, standing for the first to fourth cycle) is used to sample read data that a DQS-domain capture stage holds stable for four cycles. Each read burst comes with two feedback-pulse bits. The first is the pulse as seen at the on-time sample point. The second is the pulse as seen at an over-sample point that lags by a guard band. Both bits are taken together with the data from the first DQS of the four-beat burst.

A burst counts as a hit when either sample sees the pulse. Only hit bursts are forwarded. Misses are counted in a saturating counter. In automatic mode the block moves the cycle index one step earlier or later so that it follows DQS drift. In software mode the index is a programmed value. The block runs in a single clock domain, with abstract sample bits at its inputs.

Top module: `rd_cycle_track`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cyc_idx` is 0 and `miss_cnt` is 0.
- R2: When `burst_vld` is high and `smp_ontime` or `smp_late` is 1, `hit` and `out_vld` go high in the next cycle and `out_data` equals that burst's `burst_data`. `hit` and `out_vld` are low in every other cycle.
- R3: When `burst_vld` is high and both sample bits are 0, nothing is forwarded and `miss_cnt` rises by one in the next cycle. It saturates at all ones.
- R4: In automatic mode (`auto_mode`=1), a burst with on-time=1 and late=0 lowers `cyc_idx` by one in the next cycle. The index saturates at 0.
- R5: In automatic mode, a burst with on-time=0 and late=1 raises `cyc_idx` by one in the next cycle. The index saturates at 3.
- R6: In automatic mode, a burst with both bits 1 or both bits 0 leaves `cyc_idx` unchanged.
- R7: In software mode (`auto_mode`=0), `cyc_idx` equals `sw_idx` from the previous cycle, whatever the bursts do. Hit and miss reporting (R2, R3) still applies.
- R8: When `burst_vld` is low, the sample bits have no effect: `cyc_idx` (in automatic mode), `miss_cnt` and `out_vld` do not change because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 = automatic tracking, 0 = software index |
| sw_idx | input | 2 | Software-programmed cycle index |
| burst_vld | input | 1 | One burst result is present this cycle |
| smp_ontime | input | 1 | Feedback pulse seen at on-time sample |
| smp_late | input | 1 | Feedback pulse seen at over-sample |
| burst_data | input | DW | Burst data word |
| cyc_idx | output | 2 | Current sample-cycle index |
| hit | output | 1 | Registered hit flag for the last burst |
| out_data | output | DW | Forwarded burst data |
| out_vld | output | 1 | Forwarded data valid |
| miss_cnt | output | CW | Saturating miss counter |

## Verification
A wrong index shows up on `cyc_idx` one cycle after the burst that caused it. Because every later step starts from that value, the error also persists through the following drift bursts. A wrong hit decision shows up in the next cycle in two places: as a missing or extra `out_vld` pulse, and as a wrong `miss_cnt` step. A counter that wraps or stalls is exposed when the counter is driven to saturation. The bench keeps a behavioural model and compares every output on every clock, so any divergence is caught in the cycle it appears.

// File: rtl/rd_cycle_track.sv
module rd_cycle_track #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_mode,
  input  logic [1:0]    sw_idx,
  input  logic          burst_vld,
  input  logic          smp_ontime,
  input  logic          smp_late,
  input  logic [DW-1:0] burst_data,
  output logic [1:0]    cyc_idx,
  output logic          hit,
  output logic [DW-1:0] out_data,
  output logic          out_vld,
  output logic [CW-1:0] miss_cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  wire any_hit  = smp_ontime | smp_late;
  wire go_early = burst_vld & smp_ontime & ~smp_late;
  wire go_late  = burst_vld & ~smp_ontime & smp_late;
  wire miss     = burst_vld & ~any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_idx  <= 2'd0;
      hit      <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
      miss_cnt <= '0;
    end else begin
      hit     <= burst_vld & any_hit;
      out_vld <= burst_vld & any_hit;
      if (burst_vld & any_hit) out_data <= burst_data;
      if (miss && miss_cnt != CNT_MAX) miss_cnt <= miss_cnt + 1'b1;
      if (!auto_mode)                        cyc_idx <= sw_idx;
      else if (go_early && cyc_idx != 2'd0)  cyc_idx <= cyc_idx - 2'd1;
      else if (go_late && cyc_idx != 2'd3)   cyc_idx <= cyc_idx + 2'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (cyc_idx == 2'd0 && miss_cnt == '0));
  // R2
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_vld && (smp_ontime || smp_late)) |=> (out_vld && out_data == $past(burst_data)));
  // R3
  miss_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_vld && !smp_ontime && !smp_late) |=> !out_vld);
  // R3
  miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_vld && !smp_ontime && !smp_late && miss_cnt != CNT_MAX) |=> miss_cnt == $past(miss_cnt) + 1'b1);
  // R5
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && cyc_idx == 2'd3 && burst_vld && !smp_ontime && smp_late) |=> cyc_idx == 2'd3);
  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && (!burst_vld || smp_ontime == smp_late)) |=> $stable(cyc_idx));
  // R7
  sw_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> cyc_idx == $past(sw_idx));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_vld |=> (!out_vld && $stable(miss_cnt)));
endmodule

// File: tb/test_rd_cycle_track.sv
`timescale 1ns/1ps
module test_rd_cycle_track;
  localparam int DW = 32;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0, auto_mode = 1, burst_vld = 0, smp_ontime = 0, smp_late = 0;
  logic [1:0] sw_idx = 0;
  logic [DW-1:0] burst_data = 0;
  logic [1:0] cyc_idx;
  logic hit, out_vld;
  logic [DW-1:0] out_data;
  logic [CW-1:0] miss_cnt;
  int vecs = 0, errs = 0, cycles = 0;
  int m_idx = 0, m_cnt = 0, m_vld = 0;
  logic [DW-1:0] m_data = 0;

  rd_cycle_track #(.DW(DW), .CW(CW)) i_rd_cycle_track (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_idx = 0; m_cnt = 0; m_vld = 0; m_data = 0;
    end else begin
      m_vld = burst_vld && (smp_ontime || smp_late);
      if (m_vld) m_data = burst_data;
      if (burst_vld && !smp_ontime && !smp_late && m_cnt < 15) m_cnt++;
      if (!auto_mode) m_idx = sw_idx;
      else if (burst_vld && smp_ontime && !smp_late && m_idx > 0) m_idx--;
      else if (burst_vld && !smp_ontime && smp_late && m_idx < 3) m_idx++;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (cycles > 1) begin
    chk("R1/R4/R5/R6/R7 cyc_idx", cyc_idx, m_idx);
    chk("R3/R8 miss_cnt", miss_cnt, m_cnt);
    chk("R2/R8 out_vld", out_vld, m_vld);
    chk("R2 hit", hit, m_vld);
    if (m_vld) chk("R2 out_data", out_data, m_data);
  end

  task automatic drive(input logic v, input logic a, input logic b);
    @(posedge clk); #1;
    burst_vld = v; smp_ontime = a; smp_late = b; burst_data = $urandom;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset idx", cyc_idx, 0);
        chk("R1 reset cnt", miss_cnt, 0);
        // R5 climb and saturate at 3
        repeat (5) drive(1, 0, 1);
        // R6 both hit, idle bursts with pulse bits (R8)
        repeat (3) drive(1, 1, 1);
        repeat (3) drive(0, 0, 1);
        // R4 fall and saturate at 0
        repeat (5) drive(1, 1, 0);
        // R3 misses to saturation
        repeat (20) drive(1, 0, 0);
        // R7 software mode
        auto_mode = 0;
        for (int i = 0; i < 8; i++) begin
          sw_idx = i[1:0];
          drive(1, i[0], i[1]);
        end
        auto_mode = 1;
        // mixed random
        for (int i = 0; i < 300; i++) drive($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1));
        drive(0, 0, 0);
        repeat (3) @(posedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule